// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block receives characters from an asynchronous serial line. A programmable divider produces a sample tick. Each bit time holds 16 samples, or 8 when the double-speed option is set. The receiver waits for a falling edge on the line and confirms the start bit by a majority vote over three samples in the middle of the bit. It then samples the data bits least significant first, an optional parity bit and the first stop bit. A false start sends it back to idle.

A finished character goes into a one-character holding stage and from there into a two-entry first-in first-out buffer. Each entry keeps its own frame-error and parity-error flags. The host sees the oldest character and its flags on the read port and pops it with a one-cycle read strobe. A receive-done output shows that unread data is present. An overrun flag is raised when a new start bit is confirmed while the buffer is full and a character is still waiting in the holding stage. In multiprocessor mode the receiver keeps only address frames, which are 9-bit frames whose ninth bit is 1.

Top module: `uart_rx_core`

## Requirements
- R1: `rx_done` is 1 exactly when the buffer holds at least one unread character. Driving `rx_en` low empties the buffer and the holding stage, clears the overrun flag and returns the receiver to idle on the next clock.
- R2: A frame is one low start bit, then the data bits least significant first, then the parity bit if parity is on, then a stop bit. `char_size` selects the data length: 000 gives 5 bits, 001 gives 6, 010 gives 7, 011 gives 8 and 111 gives 9. `rd_data` holds the character right-aligned, and every bit above the character length reads 0.
- R3: When the first stop bit is sampled as 0, the character is still stored, with `rd_frame_err` set to 1. When that stop bit is 1, `rd_frame_err` is 0. Only the first stop bit is checked.
- R4: `par_mode` 10 expects an even parity bit and 11 an odd one. `rd_par_err` is 1 when the received parity bit gives the wrong parity over the data bits. With `par_mode` 00 the frame has no parity bit and `rd_par_err` is 0.
- R5: The buffer holds two characters and returns them in arrival order. Each character comes with its own error flags.
- R6: `rd_overrun` goes to 1 when a start bit is confirmed while the buffer is full and a finished character waits in the holding stage. It stays 1 until the next pop. A character that finishes while the holding stage is still occupied replaces the waiting character. A waiting character enters the buffer once a slot is free.
- R7: The sample tick period is `baud_div`+1 clocks. One bit time is 16 ticks with `dbl_speed`=0 and 8 ticks with `dbl_speed`=1.
- R8: A low pulse shorter than half a bit time is a false start. The receiver stores nothing and goes back to waiting for a new start bit.
- R9: With `mp_mode`=1 a frame is stored only when it is a 9-bit frame whose ninth data bit (bit 8 of `rd_data`) is 1. Every other frame is dropped, including all frames of 5 to 8 bits.
- R10: While the buffer is empty, `rd_data`, `rd_frame_err` and `rd_par_err` read 0, and `rd_en` has no effect.
- R11: The reserved `char_size` codes 100, 101 and 110 receive 8 data bits. The reserved `par_mode` 01 behaves like 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable; low flushes all state |
| rx_i | input | 1 | Serial line, idle high |
| baud_div | input | DIV_W | Sample tick divider, period baud_div+1 clocks |
| dbl_speed | input | 1 | 1 selects 8 samples per bit instead of 16 |
| char_size | input | 3 | Data length code |
| par_mode | input | 2 | Parity mode code |
| mp_mode | input | 1 | Keep address frames only |
| rd_en | input | 1 | Pop the head character |
| rd_data | output | 9 | Head character, right-aligned |
| rd_frame_err | output | 1 | Frame error of the head character |
| rd_par_err | output | 1 | Parity error of the head character |
| rd_overrun | output | 1 | Overrun seen since the last pop |
| rx_done | output | 1 | Buffer holds unread data |

## Verification
A wrong sample counter or a miscounted bit index shows up in `rd_data` as shifted or truncated characters, and a wrong parity sense shows up in the error flags. Both appear on the first character read after the frame ends. Faults in the buffer pointers or the holding stage show as missing, repeated or reordered characters, and as an overrun flag that does not match the arrival pattern. These appear within two or three pops. Faults in the flush and empty-state logic are visible one clock after `rx_en` falls or after the last pop.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
   localparam int unsigned MAX_BITS = 9;

   typedef enum logic [2:0] {
      ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
   } rx_state_t;

   typedef struct packed {
      logic [MAX_BITS-1:0] data;
      logic                fe;
      logic                pe;
   } rx_entry_t;

   // Data length from the size code; reserved codes fall back to 8
   function automatic logic [3:0] size_to_bits(input logic [2:0] code);
      case (code)
         3'b000:  return 4'd5;
         3'b001:  return 4'd6;
         3'b010:  return 4'd7;
         3'b111:  return 4'd9;
         default: return 4'd8;
      endcase
   endfunction

   function automatic logic vote3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction
endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   initial assert (STAGES >= 2) else $error("urx_sync: STAGES must be at least 2");

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[0] <= 1'b1;
               else        chain_q[0] <= din;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[i] <= 1'b1;
               else        chain_q[i] <= chain_q[i-1];
         end
      end
   endgenerate

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/urx_tick_gen.sv
module urx_tick_gen #(
   parameter int unsigned DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   initial assert (DIV_W >= 1) else $error("urx_tick_gen: DIV_W must be positive");

   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!en)            cnt_q <= '0;
      else if (cnt_q == '0)    cnt_q <= div;
      else                     cnt_q <= cnt_q - 1'b1;
   end

   assign tick = en && (cnt_q == '0);
endmodule

// File: rtl/urx_deframer.sv
module urx_deframer
   import uart_rx_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                tick,
   input  logic                rx,
   input  logic                dbl,
   input  logic [2:0]          size_code,
   input  logic [1:0]          par_mode,
   output logic                start_ok,
   output logic                char_vld,
   output logic [MAX_BITS-1:0] char_data,
   output logic                char_fe,
   output logic                char_pe,
   output logic                char_is9
);
   rx_state_t           st_q;
   logic [3:0]          sc_q, idx_q, nb_q;
   logic [1:0]          v_q;
   logic [MAX_BITS-1:0] sh_q;
   logic                acc_q, par_q, par_en_q, odd_q;
   logic [3:0]          last_s, mid_s;
   logic                bitv;

   always_comb begin
      last_s = dbl ? 4'd7 : 4'd15;
      mid_s  = dbl ? 4'd4 : 4'd8;
      bitv   = vote3(v_q[0], v_q[1], rx);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;   sc_q <= '0;  idx_q <= '0;  nb_q <= 4'd8;
         v_q <= '0;         sh_q <= '0;  acc_q <= 1'b0; par_q <= 1'b0;
         par_en_q <= 1'b0;  odd_q <= 1'b0;
         start_ok <= 1'b0;  char_vld <= 1'b0; char_data <= '0;
         char_fe <= 1'b0;   char_pe <= 1'b0;  char_is9 <= 1'b0;
      end else begin
         start_ok <= 1'b0;
         char_vld <= 1'b0;
         if (!en) begin
            st_q <= ST_IDLE;
         end else if (tick) begin
            if (st_q == ST_IDLE) begin
               if (!rx) begin
                  st_q     <= ST_START;
                  sc_q     <= 4'd1;
                  idx_q    <= '0;
                  nb_q     <= size_to_bits(size_code);
                  par_en_q <= par_mode[1];
                  odd_q    <= par_mode[0];
                  sh_q     <= '0;
                  acc_q    <= 1'b0;
                  par_q    <= 1'b0;
               end
            end else begin
               sc_q <= (sc_q == last_s) ? 4'd0 : sc_q + 4'd1;
               if (sc_q == mid_s - 4'd1) v_q[0] <= rx;
               if (sc_q == mid_s)        v_q[1] <= rx;
               if (sc_q == mid_s + 4'd1) begin
                  case (st_q)
                     ST_START: if (bitv) st_q <= ST_IDLE;
                               else      start_ok <= 1'b1;
                     ST_DATA: begin
                        sh_q[idx_q] <= bitv;
                        acc_q       <= acc_q ^ bitv;
                     end
                     ST_PAR:  par_q <= bitv;
                     ST_STOP: begin
                        char_vld  <= 1'b1;
                        char_data <= sh_q;
                        char_fe   <= !bitv;
                        char_pe   <= par_en_q && ((acc_q ^ par_q) != odd_q);
                        char_is9  <= (nb_q == 4'd9);
                        st_q      <= ST_IDLE;
                     end
                     default: ;
                  endcase
               end else if (sc_q == last_s) begin
                  case (st_q)
                     ST_START: st_q <= ST_DATA;
                     ST_DATA: begin
                        if (idx_q == nb_q - 4'd1) st_q <= par_en_q ? ST_PAR : ST_STOP;
                        else                      idx_q <= idx_q + 4'd1;
                     end
                     ST_PAR:  st_q <= ST_STOP;
                     default: ;
                  endcase
               end
            end
         end
      end
   end
endmodule

// File: rtl/urx_rxbuf.sv
module urx_rxbuf
   import uart_rx_pkg::*;
#(
   parameter int unsigned DEPTH = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      flush,
   input  logic      in_vld,
   input  rx_entry_t in_ent,
   input  logic      start_ok,
   input  logic      rd_en,
   output rx_entry_t head,
   output logic      nonempty,
   output logic      ovr
);
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   initial assert (DEPTH >= 2) else $error("urx_rxbuf: DEPTH must be at least 2");

   rx_entry_t            mem_q [DEPTH];
   rx_entry_t            pend_q;
   logic                 pend_v_q;
   logic [PTR_W-1:0]     wr_q, rd_q;
   logic [CNT_W-1:0]     cnt_q;
   logic                 full, pop, move;

   always_comb begin
      full     = (cnt_q == CNT_W'(DEPTH));
      nonempty = (cnt_q != '0);
      pop      = rd_en && nonempty;
      move     = pend_v_q && (!full || pop);
      head     = nonempty ? mem_q[rd_q] : '0;
   end

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q <= '0; rd_q <= '0; cnt_q <= '0;
         pend_v_q <= 1'b0; pend_q <= '0; ovr <= 1'b0;
      end else if (flush) begin
         wr_q <= '0; rd_q <= '0; cnt_q <= '0;
         pend_v_q <= 1'b0; ovr <= 1'b0;
      end else begin
         if (move) wr_q <= bump(wr_q);
         if (pop)  rd_q <= bump(rd_q);
         if (move && !pop)      cnt_q <= cnt_q + 1'b1;
         else if (pop && !move) cnt_q <= cnt_q - 1'b1;
         if (in_vld) begin
            pend_q   <= in_ent;
            pend_v_q <= 1'b1;
         end else if (move) begin
            pend_v_q <= 1'b0;
         end
         if (start_ok && pend_v_q && full) ovr <= 1'b1;
         else if (pop)                     ovr <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (move) mem_q[wr_q] <= pend_q;
   end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
   import uart_rx_pkg::*;
#(
   parameter int unsigned DIV_W       = 12,
   parameter int unsigned DEPTH       = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rx_en,
   input  logic                rx_i,
   input  logic [DIV_W-1:0]    baud_div,
   input  logic                dbl_speed,
   input  logic [2:0]          char_size,
   input  logic [1:0]          par_mode,
   input  logic                mp_mode,
   input  logic                rd_en,
   output logic [MAX_BITS-1:0] rd_data,
   output logic                rd_frame_err,
   output logic                rd_par_err,
   output logic                rd_overrun,
   output logic                rx_done
);
   logic                rx_s, tick, start_ok, char_vld, keep;
   logic [MAX_BITS-1:0] char_data;
   logic                char_fe, char_pe, char_is9;
   rx_entry_t           in_ent, head;

   urx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(rx_i), .dout(rx_s));

   urx_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .en(rx_en), .div(baud_div), .tick(tick));

   urx_deframer u_dfr (
      .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick), .rx(rx_s),
      .dbl(dbl_speed), .size_code(char_size), .par_mode(par_mode),
      .start_ok(start_ok), .char_vld(char_vld), .char_data(char_data),
      .char_fe(char_fe), .char_pe(char_pe), .char_is9(char_is9));

   // Address filter: only 9-bit frames with the top data bit set survive
   always_comb begin
      keep        = !mp_mode || (char_is9 && char_data[MAX_BITS-1]);
      in_ent.data = char_data;
      in_ent.fe   = char_fe;
      in_ent.pe   = char_pe;
   end

   urx_rxbuf #(.DEPTH(DEPTH)) u_buf (
      .clk(clk), .rst_n(rst_n), .flush(!rx_en),
      .in_vld(char_vld && keep), .in_ent(in_ent), .start_ok(start_ok),
      .rd_en(rd_en), .head(head), .nonempty(rx_done), .ovr(rd_overrun));

   assign rd_data      = head.data;
   assign rd_frame_err = head.fe;
   assign rd_par_err   = head.pe;
endmodule

// File: rtl/urx_checker.sv
module urx_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       rx_en,
   input logic       rd_en,
   input logic [8:0] rd_data,
   input logic       rd_frame_err,
   input logic       rd_par_err,
   input logic       rd_overrun,
   input logic       rx_done
);
   p_flush_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !rx_done);

   p_done_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && !rd_en && rx_en) |=> rx_done);

   p_flush_ovr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !rd_overrun);

   p_ovr_has_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_overrun |-> rx_done);

   p_empty_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_done |-> (rd_data == 9'd0 && !rd_frame_err && !rd_par_err));
endmodule

bind uart_rx_core urx_checker u_chk (
   .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rd_en(rd_en),
   .rd_data(rd_data), .rd_frame_err(rd_frame_err), .rd_par_err(rd_par_err),
   .rd_overrun(rd_overrun), .rx_done(rx_done));

// File: tb/uart_rx_core_tb_top.sv
module uart_rx_core_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_en = 1'b0;
   logic        rx_i = 1'b1;
   logic [11:0] baud_div = 12'd1;
   logic        dbl_speed = 1'b0;
   logic [2:0]  char_size = 3'b011;
   logic [1:0]  par_mode = 2'b00;
   logic        mp_mode = 1'b0;
   logic        rd_en = 1'b0;
   logic [8:0]  rd_data;
   logic        rd_frame_err, rd_par_err, rd_overrun, rx_done;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   uart_rx_core dut_i (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_i(rx_i),
      .baud_div(baud_div), .dbl_speed(dbl_speed), .char_size(char_size),
      .par_mode(par_mode), .mp_mode(mp_mode), .rd_en(rd_en),
      .rd_data(rd_data), .rd_frame_err(rd_frame_err), .rd_par_err(rd_par_err),
      .rd_overrun(rd_overrun), .rx_done(rx_done));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int bit_clks();
      return (dbl_speed ? 8 : 16) * (int'(baud_div) + 1);
   endfunction

   task automatic hold_line(input logic v, input int n);
      rx_i = v;
      repeat (n) @(negedge clk);
   endtask

   // One frame: start, nb data bits LSB first, optional parity bit, stop
   task automatic send(input logic [8:0] d, input int nb, input bit with_par,
                       input logic pbit, input logic stop);
      int b = bit_clks();
      hold_line(1'b0, b);
      for (int i = 0; i < nb; i++) hold_line(d[i], b);
      if (with_par) hold_line(pbit, b);
      hold_line(stop, b);
      rx_i = 1'b1;
   endtask

   function automatic logic parity_of(input logic [8:0] d, input int nb, input bit odd);
      logic p = odd;
      for (int i = 0; i < nb; i++) p ^= d[i];
      return p;
   endfunction

   task automatic settle();
      repeat (12) @(negedge clk);
   endtask

   task automatic read_expect(input string req, input int d, input int fe,
                              input int pe, input int ov);
      check({req, " done"}, rx_done, 1);
      check({req, " data"}, rd_data, d);
      check({req, " frame_err"}, rd_frame_err, fe);
      check({req, " par_err"}, rd_par_err, pe);
      check({req, " overrun"}, rd_overrun, ov);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 reset done", rx_done, 0);
      check("R10 reset data", rd_data, 0);
      check("R6 reset overrun", rd_overrun, 0);
   endtask

   task automatic t_sizes();
      char_size = 3'b011; send(9'h0A5, 8, 0, 0, 1); settle();
      read_expect("R2 8-bit", 9'h0A5, 0, 0, 0);
      char_size = 3'b000; send(9'h1F5, 5, 0, 0, 1); settle();
      read_expect("R2 5-bit upper zero", 9'h015, 0, 0, 0);
      char_size = 3'b010; send(9'h04E, 7, 0, 0, 1); settle();
      read_expect("R2 7-bit", 9'h04E, 0, 0, 0);
      char_size = 3'b111; send(9'h16C, 9, 0, 0, 1); settle();
      read_expect("R2 9-bit", 9'h16C, 0, 0, 0);
      char_size = 3'b101; send(9'h0C3, 8, 0, 0, 1); settle();
      read_expect("R11 reserved size as 8", 9'h0C3, 0, 0, 0);
      char_size = 3'b011;
   endtask

   task automatic t_frame_err();
      send(9'h05A, 8, 0, 0, 0); hold_line(1'b1, bit_clks()); settle();
      read_expect("R3 stop low", 9'h05A, 1, 0, 0);
      check("R3 nothing extra after bad stop", rx_done, 0);
   endtask

   task automatic t_parity();
      par_mode = 2'b10;
      send(9'h0B7, 8, 1, parity_of(9'h0B7, 8, 0), 1); settle();
      read_expect("R4 even good", 9'h0B7, 0, 0, 0);
      send(9'h0B7, 8, 1, !parity_of(9'h0B7, 8, 0), 1); settle();
      read_expect("R4 even bad", 9'h0B7, 0, 1, 0);
      par_mode = 2'b11;
      send(9'h031, 8, 1, parity_of(9'h031, 8, 1), 1); settle();
      read_expect("R4 odd good", 9'h031, 0, 0, 0);
      send(9'h031, 8, 1, !parity_of(9'h031, 8, 1), 1); settle();
      read_expect("R4 odd bad", 9'h031, 0, 1, 0);
      par_mode = 2'b01;
      send(9'h0E2, 8, 0, 0, 1); settle();
      read_expect("R11 reserved parity as none", 9'h0E2, 0, 0, 0);
      par_mode = 2'b00;
   endtask

   task automatic t_order();
      send(9'h011, 8, 0, 0, 0);
      hold_line(1'b1, bit_clks());
      send(9'h022, 8, 0, 0, 1); settle();
      read_expect("R5 first with own flag", 9'h011, 1, 0, 0);
      read_expect("R5 second clean", 9'h022, 0, 0, 0);
      check("R10 empty after two pops", rx_done, 0);
   endtask

   task automatic t_overrun();
      send(9'h0A1, 8, 0, 0, 1);
      send(9'h0B2, 8, 0, 0, 1);
      send(9'h0C3, 8, 0, 0, 1);
      send(9'h0D4, 8, 0, 0, 1); settle();
      read_expect("R6 head flags overrun", 9'h0A1, 0, 0, 1);
      read_expect("R6 overrun cleared by pop", 9'h0B2, 0, 0, 0);
      read_expect("R6 waiting char replaced", 9'h0D4, 0, 0, 0);
      check("R6 buffer drained", rx_done, 0);
   endtask

   task automatic t_speed();
      dbl_speed = 1'b1; baud_div = 12'd3;
      send(9'h069, 8, 0, 0, 1); settle();
      read_expect("R7 8x oversample div 3", 9'h069, 0, 0, 0);
      dbl_speed = 1'b0; baud_div = 12'd2;
      send(9'h096, 8, 0, 0, 1); settle();
      read_expect("R7 16x oversample div 2", 9'h096, 0, 0, 0);
      baud_div = 12'd1;
   endtask

   task automatic t_glitch();
      hold_line(1'b0, 3);
      hold_line(1'b1, 3 * bit_clks());
      check("R8 glitch stores nothing", rx_done, 0);
      send(9'h03C, 8, 0, 0, 1); settle();
      read_expect("R8 receive after false start", 9'h03C, 0, 0, 0);
   endtask

   task automatic t_mp();
      mp_mode = 1'b1; char_size = 3'b111;
      send(9'h055, 9, 0, 0, 1); settle();
      check("R9 data frame dropped", rx_done, 0);
      send(9'h133, 9, 0, 0, 1); settle();
      read_expect("R9 address frame kept", 9'h133, 0, 0, 0);
      char_size = 3'b011;
      send(9'h0FF, 8, 0, 0, 1); settle();
      check("R9 8-bit frame dropped", rx_done, 0);
      mp_mode = 1'b0;
   endtask

   task automatic t_empty_read();
      rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; @(negedge clk);
      check("R10 empty read done", rx_done, 0);
      check("R10 empty read data", rd_data, 0);
      send(9'h07E, 8, 0, 0, 1); settle();
      read_expect("R10 next char intact", 9'h07E, 0, 0, 0);
   endtask

   task automatic t_flush();
      send(9'h044, 8, 0, 0, 1); settle();
      check("R1 done with data", rx_done, 1);
      rx_en = 1'b0; @(negedge clk);
      check("R1 flush clears done", rx_done, 0);
      rx_en = 1'b1; @(negedge clk);
      check("R1 stays empty after enable", rx_done, 0);
      send(9'h088, 8, 0, 0, 1); settle();
      read_expect("R1 receive after flush", 9'h088, 0, 0, 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      rx_en = 1'b1;
      repeat (4) @(negedge clk);
      t_sizes();
      t_frame_err();
      t_parity();
      t_order();
      t_overrun();
      t_speed();
      t_glitch();
      t_mp();
      t_empty_read();
      t_flush();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule